// File: doc/BRIEF.md
# Parallel/Serial-In Serial-Out Shift Register

This block is a chain of flip-flop stages (eight by default) that either takes one bit per clock from a serial input or takes a whole word at once from a bank of parallel inputs. A single mode input chooses between the two. When mode is low, every rising clock edge moves the contents one place toward the last stage and puts the serial bit into stage 1. When mode is high, each stage takes its own parallel bit. The outputs come from the last three stages, which are stages 6, 7 and 8 at the default size.

A build-time parameter sets when a parallel load takes place. In the clocked style, the word is captured on a rising edge while mode is high. In the forced style, the word enters the stages as soon as mode rises, with no clock needed. Clock edges that arrive while mode stays high then only recapture the same word, and the stages keep that word after mode falls until the next edge shifts. Serial shifting is clocked in both styles. A longer register is made by wiring the last-stage output of one instance to the serial input of the next.

An active-low reset clears every stage at once. The clear is released through a short synchronizer, so it ends on a clock edge.

Top module: `piso_shift8`

## Requirements
- R1: While rst_n is low, every stage reads 0, and all three taps read 0 without waiting for a clock edge.
- R2: With mode_load low (0 = shift), each rising clock edge gives stage k+1 the old value of stage k and gives stage 1 the value of ser_in.
- R3: With ASYNC_LOAD = 0 and mode_load high (1 = load), a rising edge gives stage k the value of par_in[k-1]. Stage 1 takes bit 0, and afterwards tap_s8 equals par_in[STAGES-1].
- R4: With ASYNC_LOAD = 0, raising mode_load with no clock edge leaves all taps unchanged.
- R5: With ASYNC_LOAD = 1, the taps show the parallel word (tap_s6 = par_in[5], tap_s7 = par_in[6], tap_s8 = par_in[7]) as soon as mode_load rises, before any clock edge.
- R6: With ASYNC_LOAD = 1, rising edges while mode_load is high do not shift. After mode_load falls, the loaded word is held until the next rising edge.
- R7: tap_s6, tap_s7 and tap_s8 read stages STAGES-2, STAGES-1 and STAGES, which are stages 6, 7 and 8 by default.
- R8: When tap_s8 of one instance drives ser_in of a second instance, and both share clk and mode_load, the pair acts as a 16-stage register.
- R9: After a parallel load, the first edge with mode_load low shifts the loaded contents. A serial stream that is interrupted by a load continues from the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register changes on the rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases on a clock edge |
| mode_load | input | 1 | 0 = shift in serially, 1 = load the parallel word |
| ser_in | input | 1 | Serial data into stage 1 |
| par_in | input | STAGES | Parallel word; bit k-1 goes into stage k |
| tap_s6 | output | 1 | Stage STAGES-2 (stage 6 by default) |
| tap_s7 | output | 1 | Stage STAGES-1 (stage 7 by default) |
| tap_s8 | output | 1 | Last stage; drives the next instance in a chain |

## Verification
Two functions can land in the same cycle: a load request and a clock edge. The bench raises mode_load at a falling clock edge and samples one nanosecond later. At that point the clocked instance must still show its old contents, and the forced instance must already show the parallel word. The next rising edge, with mode_load still high, must reload the word and must not shift. The fall of mode_load is checked the same way: the word is held until the next edge, which then resumes shifting from that word.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;
  localparam int PSR_DEF_STAGES = 8;
  localparam int PSR_RST_SYNC   = 2;

  typedef enum logic {
    PSR_SHIFT = 1'b0,
    PSR_LOAD  = 1'b1
  } psr_mode_e;
endpackage

// File: rtl/psr_rst_sync.sv
`timescale 1ns/1ps
module psr_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[DEPTH-1];
endmodule

// File: rtl/psr_stage.sv
`timescale 1ns/1ps
module psr_stage #(
  parameter bit ASYNC_LOAD = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift_d,
  input  logic load_d,
  output logic q
);
  logic d_nxt;

  always_comb begin
    d_nxt = load ? load_d : shift_d;
  end

  generate
    if (ASYNC_LOAD) begin : g_forced
      always_ff @(posedge clk or negedge rst_n or posedge load) begin
        if (!rst_n) begin
          q <= 1'b0;
        end else if (load) begin
          q <= load_d;
        end else begin
          q <= d_nxt;
        end
      end
    end else begin : g_clocked
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= 1'b0;
        end else begin
          q <= d_nxt;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/piso_shift8.sv
`timescale 1ns/1ps
module piso_shift8
  import psr_pkg::*;
#(
  parameter int STAGES     = PSR_DEF_STAGES,
  parameter bit ASYNC_LOAD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              tap_s6,
  output logic              tap_s7,
  output logic              tap_s8
);
  localparam int LAST = STAGES - 1;

  logic              rst_sync_n;
  psr_mode_e         mode_e;
  logic              load_req;
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] shift_src;

  psr_rst_sync #(.DEPTH(PSR_RST_SYNC)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign mode_e    = psr_mode_e'(mode_load);
  assign load_req  = (mode_e == PSR_LOAD);
  assign shift_src = {stg_q[LAST-1:0], ser_in};

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    psr_stage #(.ASYNC_LOAD(ASYNC_LOAD)) u_stage (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load    (load_req),
      .shift_d (shift_src[k]),
      .load_d  (par_in[k]),
      .q       (stg_q[k])
    );
  end

  assign tap_s8 = stg_q[LAST];
  assign tap_s7 = stg_q[LAST-1];
  assign tap_s6 = stg_q[LAST-2];
endmodule

// File: rtl/piso_shift8_chk.sv
`timescale 1ns/1ps
module piso_shift8_chk #(
  parameter int STAGES     = 8,
  parameter bit ASYNC_LOAD = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ok,
  input logic              mode_load,
  input logic              ser_in,
  input logic              par_msb,
  input logic [STAGES-1:0] stg_q,
  input logic              tap_s6,
  input logic              tap_s7,
  input logic              tap_s8
);
  p_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (stg_q == '0));

  p_serial_entry_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !mode_load |=> (mode_load || stg_q[0] == $past(ser_in)));

  p_last_shift_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !mode_load |=> (mode_load || tap_s8 == $past(tap_s7)));

  p_mid_taps_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !mode_load |=> (mode_load || tap_s7 == $past(tap_s6)));

  p_load_edge_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    mode_load |=> (tap_s8 == $past(par_msb)));

  p_forced_load_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (ASYNC_LOAD && mode_load) |-> (tap_s8 == par_msb));
endmodule

bind piso_shift8 piso_shift8_chk #(
  .STAGES     (STAGES),
  .ASYNC_LOAD (ASYNC_LOAD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_ok    (rst_sync_n),
  .mode_load (mode_load),
  .ser_in    (ser_in),
  .par_msb   (par_in[STAGES-1]),
  .stg_q     (stg_q),
  .tap_s6    (tap_s6),
  .tap_s7    (tap_s7),
  .tap_s8    (tap_s8)
);

// File: tb/piso_shift8_bench.sv
`timescale 1ns/1ps
module piso_shift8_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       mode;
  logic       ser;
  logic [7:0] par_lo;
  logic [7:0] par_hi;
  logic lo6, lo7, lo8, hi6, hi7, hi8, as6, as7, as8;

  piso_shift8 #(.STAGES(8), .ASYNC_LOAD(1'b0)) u_piso_shift8 (
    .clk(clk), .rst_n(rst_n), .mode_load(mode), .ser_in(ser), .par_in(par_lo),
    .tap_s6(lo6), .tap_s7(lo7), .tap_s8(lo8));

  piso_shift8 #(.STAGES(8), .ASYNC_LOAD(1'b0)) u_piso_shift8_hi (
    .clk(clk), .rst_n(rst_n), .mode_load(mode), .ser_in(lo8), .par_in(par_hi),
    .tap_s6(hi6), .tap_s7(hi7), .tap_s8(hi8));

  piso_shift8 #(.STAGES(8), .ASYNC_LOAD(1'b1)) u_piso_shift8_async (
    .clk(clk), .rst_n(rst_n), .mode_load(mode), .ser_in(ser), .par_in(par_lo),
    .tap_s6(as6), .tap_s7(as7), .tap_s8(as8));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [16:1] m;
  logic [8:1]  a;
  logic [8:0]  exp_q[$];
  string       tag_q[$];

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [8:0] act_vec();
    return {lo6, lo7, lo8, hi6, hi7, hi8, as6, as7, as8};
  endfunction

  function automatic logic [8:0] model_vec();
    return {m[6], m[7], m[8], m[14], m[15], m[16], a[6], a[7], a[8]};
  endfunction

  // Driver: applies inputs at the falling edge, checks the between-edge
  // effects of a mode change, then predicts the rising-edge result.
  task automatic step(input logic s, input logic md, input logic [7:0] pl,
                      input logic [7:0] ph, input string tag);
    logic prev;
    @(negedge clk);
    prev   = mode;
    ser    = s;
    mode   = md;
    par_lo = pl;
    par_hi = ph;
    #1;
    if (md && !prev) begin
      chk({tag, " R4 clocked load waits for edge"},
          {3'b000, lo6, lo7, lo8, hi6, hi7, hi8},
          {3'b000, m[6], m[7], m[8], m[14], m[15], m[16]});
      for (int k = 1; k <= 8; k++) a[k] = pl[k-1];
      chk({tag, " R5 forced load without edge"},
          {6'b0, as6, as7, as8}, {6'b0, pl[5], pl[6], pl[7]});
    end
    if (!md && prev) begin
      chk({tag, " R6 forced word held after mode falls"},
          {6'b0, as6, as7, as8}, {6'b0, a[6], a[7], a[8]});
    end
    @(posedge clk);
    if (md) begin
      for (int k = 1; k <= 8; k++) begin
        m[k]   = pl[k-1];
        m[k+8] = ph[k-1];
        a[k]   = pl[k-1];
      end
    end else begin
      m = {m[15:1], s};
      a = {a[7:1], s};
    end
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  // Monitor: compares each predicted result just after the edge it belongs to.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        chk(tag_q.pop_front(), act_vec(), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    rst_n = 1'b0; mode = 1'b0; ser = 1'b0; par_lo = '0; par_hi = '0;
    m = '0; a = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", act_vec(), 9'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 zero after release", act_vec(), 9'b0);

    // Serial stream through the 16-stage chain.
    pat = 16'hB3C5;
    for (int i = 0; i < 16; i++) step(pat[i], 1'b0, 8'h00, 8'h00, "R2 R7 R8 serial shift");

    // Load, hold the load over an extra edge, then resume shifting.
    step(1'b0, 1'b1, 8'hA5, 8'h3C, "R3 parallel load");
    step(1'b1, 1'b1, 8'hA5, 8'h3C, "R6 edge during load");
    for (int i = 0; i < 10; i++) step(i[0], 1'b0, 8'hA5, 8'h3C, "R9 R8 resume from loaded word");

    // Mode change in the middle of a stream.
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h00, 8'h00, "R2 stream start");
    step(1'b0, 1'b1, 8'h5A, 8'hC3, "R3 mid-stream load");
    for (int i = 0; i < 5; i++) step(~i[0], 1'b0, 8'h5A, 8'hC3, "R9 stream continues");

    // Only the top parallel bit set: it must appear on the last stage.
    step(1'b0, 1'b1, 8'h80, 8'h01, "R3 bit 8 to last stage");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h80, 8'h01, "R7 R8 taps after load");

    // Asynchronous clear while the stages hold ones.
    step(1'b1, 1'b1, 8'hFF, 8'hFF, "R3 all-ones load");
    step(1'b1, 1'b0, 8'hFF, 8'hFF, "R2 shift ones");
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    rst_n = 1'b0;
    ser   = 1'b0;
    #1;
    chk("R1 asynchronous clear", act_vec(), 9'b0);
    m = '0; a = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 held clear after release", act_vec(), 9'b0);

    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule